// File: doc/BRIEF.md
# Local Interrupt Controller Countdown Timer

This block is the countdown timer that sits beside each processor's local interrupt controller. Software programs it through a small register-write port. A control word chooses one-shot or periodic operation and can mask the interrupt. A divide setting scales the base clock by a power of two. Writing a starting count arms the timer. The live count is always visible on a read port. A one-cycle interrupt request pulse marks each expiry.

The core is a three-state machine. TS_IDLE is the state after reset, before any count has been loaded. TS_RUN is active counting. TS_HALT holds the count at zero, either after a one-shot expiry or after a zero count was loaded. Its transitions are as follows:
- LOAD: a write of the starting count, from any state. It enters TS_RUN for a nonzero value and TS_HALT for zero.
- DECREMENT: a prescaled tick in TS_RUN while the count is nonzero. The state stays TS_RUN.
- RELOAD: a tick at zero in periodic mode. The state stays TS_RUN.
- EXPIRE: a tick at zero in one-shot mode. It goes from TS_RUN to TS_HALT.

Register select on `cfg_sel`: 0 is the starting count (32 bits), 1 is the divide setting, 2 is the control word (bit 0 mask, bit 1 periodic), and 3 is not decoded.

Top module: `lic_timer`

## Requirements
- R1: After reset `cur_count` is 0 and `irq` is low. The control word resets to mask set and one-shot mode. The prescale shift resets to 0, so the count moves on every clock until the divide setting is written.
- R2: The divide setting uses data bits 3, 1 and 0 as a 3-bit code {b3,b1,b0}. Codes 0 to 6 select shifts 1 to 7 (divide by 2 to 128), and code 7 selects shift 0 (divide by 1). A prescaled tick occurs once every 2^shift clocks.
- R3: A write of the starting count N sets `cur_count` to N at the next clock edge and restarts the prescaler. The first decrement comes 2^shift clocks after that edge, and each later one follows 2^shift clocks after the previous.
- R4: In one-shot mode the count reaches 0 after N ticks. On tick N+1, `irq` pulses and the count stays at 0. No further pulse follows until a new starting count is written.
- R5: In periodic mode, a tick at count 0 reloads N and pulses `irq` in the same cycle in which `cur_count` shows N again. Pulses therefore repeat every N+1 ticks.
- R6: A starting count of 0 holds `cur_count` at 0 and never raises `irq`, in either mode. Writing 0 during a run stops the timer.
- R7: With the mask bit set, `irq` stays low, while `cur_count` keeps counting and reloading as it would unmasked.
- R8: `irq` is high for exactly one clock per expiry.
- R9: Writing a new starting count in the middle of a run abandons the old count. Counting then continues from the new value, with the timing of R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 count, 1 divide, 2 control) |
| cfg_wdata | input | 32 | Write data |
| cur_count | output | 32 | Live current count |
| irq | output | 1 | One-cycle expiry pulse |

## Verification
The bench checks the off-by-one at the end of a period. It expects one extra tick at zero before expiry. A design that fired as the count reached zero would pulse one tick early, and in periodic mode it would shorten every period. All eight divide codes are measured, including the wrap of code 7 to divide-by-1 and the reset shift of 0. A decoder without that wrap would count 128 times too slowly. The bench also loads zero in both modes, masks the timer while it runs, and reloads it mid-run. A design that decremented through zero, fired with the mask set, or kept the old prescaler phase after a reload would show a wrong count or a stray pulse.

// File: rtl/lic_timer_pkg.sv
package lic_timer_pkg;

    localparam int SHIFT_W = 3;

    typedef enum logic [1:0] {
        TS_IDLE = 2'd0,
        TS_RUN  = 2'd1,
        TS_HALT = 2'd2
    } tmr_state_e;

    typedef enum logic [1:0] {
        SEL_COUNT = 2'd0,
        SEL_DIV   = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_NONE  = 2'd3
    } cfg_sel_e;

    // {b3,b1,b0}: codes 0..6 give shifts 1..7, code 7 wraps to shift 0
    function automatic logic [SHIFT_W-1:0] div_to_shift(input logic [3:0] d);
        logic [SHIFT_W-1:0] code;
        code = {d[3], d[1:0]};
        return code + SHIFT_W'(1);
    endfunction

endpackage

// File: rtl/lic_timer_cfg.sv
module lic_timer_cfg
    import lic_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [1:0]         sel,
    input  logic [CNT_W-1:0]   wdata,
    output logic [CNT_W-1:0]   init_q,
    output logic [SHIFT_W-1:0] shift_q,
    output logic               mask_q,
    output logic               periodic_q,
    output logic               load,
    output logic               restart
);

    cfg_sel_e sel_e;

    always_comb begin
        sel_e   = cfg_sel_e'(sel);
        load    = we && (sel_e == SEL_COUNT);
        restart = load || (we && (sel_e == SEL_DIV));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_q     <= '0;
            shift_q    <= '0;
            mask_q     <= 1'b1;
            periodic_q <= 1'b0;
        end else if (we) begin
            unique case (sel_e)
                SEL_COUNT: init_q  <= wdata;
                SEL_DIV:   shift_q <= div_to_shift(wdata[3:0]);
                SEL_CTRL: begin
                    mask_q     <= wdata[0];
                    periodic_q <= wdata[1];
                end
                SEL_NONE: ;
            endcase
        end
    end

endmodule

// File: rtl/lic_timer_prescale.sv
module lic_timer_prescale
    import lic_timer_pkg::*;
#(
    parameter int PRE_W = (1 << SHIFT_W) - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic [SHIFT_W-1:0] shift,
    output logic               tick
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] lim;

    always_comb begin
        lim  = (PRE_W'(1) << shift) - PRE_W'(1);
        tick = (pre_q == lim);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || restart || tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

endmodule

// File: rtl/lic_timer_count.sv
module lic_timer_count
    import lic_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] init_q,
    input  logic             tick,
    input  logic             periodic,
    input  logic             mask,
    output logic [CNT_W-1:0] count_q,
    output logic             irq_q
);

    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_d;
    logic             fire_d;

    // next state and next outputs
    always_comb begin
        state_d = state_q;
        count_d = count_q;
        fire_d  = 1'b0;
        if (load) begin
            count_d = load_val;
            state_d = (load_val == '0) ? TS_HALT : TS_RUN;
        end else begin
            unique case (state_q)
                TS_IDLE: ;
                TS_RUN: begin
                    if (tick) begin
                        if (count_q != '0) begin
                            count_d = count_q - CNT_W'(1);
                        end else if (periodic) begin
                            count_d = init_q;
                            fire_d  = !mask;
                        end else begin
                            state_d = TS_HALT;
                            fire_d  = !mask;
                        end
                    end
                end
                TS_HALT: count_d = '0;
                default: state_d = TS_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TS_IDLE;
        else        state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            count_q <= count_d;
            irq_q   <= fire_d;
        end
    end

endmodule

// File: rtl/lic_timer.sv
module lic_timer
    import lic_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [CNT_W-1:0] cfg_wdata,
    output logic [CNT_W-1:0] cur_count,
    output logic             irq
);

    logic [CNT_W-1:0]   init_w;
    logic [SHIFT_W-1:0] shift_w;
    logic               mask_w;
    logic               periodic_w;
    logic               load_w;
    logic               restart_w;
    logic               tick_w;

    lic_timer_cfg #(.CNT_W(CNT_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (cfg_we),
        .sel        (cfg_sel),
        .wdata      (cfg_wdata),
        .init_q     (init_w),
        .shift_q    (shift_w),
        .mask_q     (mask_w),
        .periodic_q (periodic_w),
        .load       (load_w),
        .restart    (restart_w)
    );

    lic_timer_prescale u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart_w),
        .shift   (shift_w),
        .tick    (tick_w)
    );

    lic_timer_count #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_w),
        .load_val (cfg_wdata),
        .init_q   (init_w),
        .tick     (tick_w),
        .periodic (periodic_w),
        .mask     (mask_w),
        .count_q  (cur_count),
        .irq_q    (irq)
    );

endmodule

// File: rtl/lic_timer_chk.sv
module lic_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic [CNT_W-1:0] cur_count,
    input logic [CNT_W-1:0] init_val,
    input logic             mask,
    input logic             periodic
);

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    a_r7_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !$past(mask));

    a_r4_fire_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(cur_count) == '0));

    a_r5_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(periodic)) |-> (cur_count == $past(init_val)));

    a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cur_count <= init_val);

endmodule

bind lic_timer lic_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (irq),
    .cur_count (cur_count),
    .init_val  (init_w),
    .mask      (mask_w),
    .periodic  (periodic_w)
);

// File: tb/lic_timer_tb_top.sv
module lic_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cur_count;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int irq_cnt = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lic_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cur_count (cur_count),
        .irq       (irq)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (irq) irq_cnt <= irq_cnt + 1;
    end

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic quiesce();
        wr(2'd2, 32'h1);
        wr(2'd0, 32'd0);
        wr(2'd1, 32'hB);
    endtask

    task automatic t_reset();
        int c0;
        chk("R1", "reset count", cur_count, 0);
        chk("R1", "reset irq", irq, 0);
        c0 = irq_cnt;
        wr(2'd0, 32'd1);
        wait_n(1);
        chk("R1", "shift 0 after reset", cur_count, 0);
        wait_n(6);
        chk("R1", "masked one-shot after reset, count", cur_count, 0);
        chk("R1", "masked after reset, irq count", irq_cnt - c0, 0);
    endtask

    task automatic t_oneshot();
        int c0;
        wr(2'd2, 32'h0);
        c0 = irq_cnt;
        wr(2'd0, 32'd5);
        chk("R3", "load value", cur_count, 5);
        wait_n(5);
        chk("R4", "reaches zero", cur_count, 0);
        chk("R4", "no early irq", irq, 0);
        wait_n(1);
        chk("R4", "irq on tick N+1", irq, 1);
        chk("R4", "holds zero", cur_count, 0);
        wait_n(1);
        chk("R8", "pulse one cycle", irq, 0);
        wait_n(20);
        chk("R4", "holds zero later", cur_count, 0);
        chk("R4", "single expiry", irq_cnt - c0, 1);
    endtask

    task automatic t_periodic();
        int c0;
        wr(2'd2, 32'h2);
        c0 = irq_cnt;
        wr(2'd0, 32'd3);
        wait_n(4);
        chk("R5", "first expiry irq", irq, 1);
        chk("R5", "reloaded", cur_count, 3);
        wait_n(1);
        chk("R8", "pulse ends", irq, 0);
        chk("R5", "counting again", cur_count, 2);
        wait_n(3);
        chk("R5", "second expiry irq", irq, 1);
        chk("R5", "reloaded again", cur_count, 3);
        wait_n(11);
        chk("R5", "count at 19 cycles", cur_count, 0);
        chk("R5", "four expiries", irq_cnt - c0, 4);
        quiesce();
    endtask

    task automatic t_divide();
        for (int c = 0; c < 8; c++) begin
            int s;
            int k;
            logic [2:0] cb;
            cb = 3'(c);
            s = (c + 1) % 8;
            k = 1 << s;
            wr(2'd2, 32'h1);
            wr(2'd1, {28'd0, cb[2], 1'b0, cb[1:0]});
            wr(2'd0, 32'd100);
            wait_n(3 * k - 1);
            chk("R2", $sformatf("code %0d before third tick", c), cur_count, 98);
            wait_n(1);
            chk("R3", $sformatf("code %0d at third tick", c), cur_count, 97);
        end
        quiesce();
    endtask

    task automatic t_zero();
        int c0;
        wr(2'd2, 32'h0);
        wr(2'd0, 32'd5);
        wait_n(2);
        c0 = irq_cnt;
        wr(2'd0, 32'd0);
        chk("R6", "one-shot zero stops", cur_count, 0);
        wait_n(10);
        chk("R6", "one-shot zero holds", cur_count, 0);
        chk("R6", "one-shot zero no irq", irq_cnt - c0, 0);
        wr(2'd2, 32'h2);
        c0 = irq_cnt;
        wr(2'd0, 32'd0);
        wait_n(10);
        chk("R6", "periodic zero holds", cur_count, 0);
        chk("R6", "periodic zero no irq", irq_cnt - c0, 0);
    endtask

    task automatic t_mask();
        int c0;
        wr(2'd2, 32'h3);
        c0 = irq_cnt;
        wr(2'd0, 32'd2);
        wait_n(4);
        chk("R7", "masked count after reload", cur_count, 1);
        wait_n(8);
        chk("R7", "masked count at 12", cur_count, 2);
        chk("R7", "no irq while masked", irq_cnt - c0, 0);
        quiesce();
    endtask

    task automatic t_reload();
        wr(2'd2, 32'h2);
        wr(2'd0, 32'd10);
        wait_n(4);
        chk("R9", "before rewrite", cur_count, 6);
        wr(2'd0, 32'd3);
        chk("R9", "new value loaded", cur_count, 3);
        wait_n(2);
        chk("R9", "counts from new value", cur_count, 1);
        wait_n(2);
        chk("R9", "expiry uses new period", irq, 1);
        chk("R9", "reload to new value", cur_count, 3);
        quiesce();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        quiesce();
        t_oneshot();
        t_periodic();
        t_divide();
        t_zero();
        t_mask();
        t_reload();
        done = 1'b1;
    end

    initial begin
        wait (done || cycles > 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule